// File: doc/BRIEF.md
# Selectable Hardware/Software Clock Gate Controller

This block decides whether one clock branch runs. Its enable comes from one of two places. In automatic mode it follows a hardware request line, so the clock runs while a consumer asks for it and stops once the consumer goes idle. In software mode it follows an enable bit that software writes. A select bit, which can change at run time, picks the mode. The gate itself is modelled as a registered enable, `gate_en_o`, which would drive a glitch-free clock cell.

In automatic mode an optional idle delay holds the clock on for a short or a long number of idle cycles before the gate closes. A fresh request during that countdown cancels the pending gate-off. A read-only status bit gives the gate state after a fixed two-cycle synchronisation delay. Software polls that bit to confirm that a requested change has taken effect.

A build-time parameter selects a hardware-only variant. In that variant the select and enable fields have no effect and the gate always follows the request line.

Top module: `ckgate_ctrl`

## Requirements
- R1: After synchronous reset, the controller is in software mode with the enable bit set, so `gate_en_o` = 1 and `status_o` = 1, and both stay high while `hw_req_i` is low.
- R2: In software mode (select field 1), `gate_en_o` takes the value of the enable field one clock edge after the edge that captures the configuration write. The enable field is 0 = off and 1 = on.
- R3: In automatic mode (select field 0), a high `hw_req_i` sampled at a clock edge makes `gate_en_o` 1 at that edge.
- R4: In automatic mode with the idle delay disabled (hyst-enable field 0), `gate_en_o` goes to 0 at the first edge that samples `hw_req_i` low.
- R5: In automatic mode with the idle delay enabled and the length field 0 (short delay), `gate_en_o` goes to 0 at the 8th consecutive edge that samples `hw_req_i` low, and not before.
- R6: With the idle delay enabled and the length field 1 (long delay), `gate_en_o` goes to 0 at the 64th consecutive idle edge, and not before.
- R7: A high `hw_req_i` at any edge of the countdown, including the edge on which the gate would have closed, keeps `gate_en_o` at 1 and restarts the idle count from zero.
- R8: `status_o` equals the value `gate_en_o` had two clock edges earlier, in both modes.
- R9: In the hardware-only variant (HW_ONLY = 1), writes to the select and enable fields have no effect, and `gate_en_o` always follows the automatic rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Select field: 1 = software control, 0 = automatic |
| cfg_en_i | input | 1 | Software enable field: 1 = on, 0 = off |
| cfg_hyst_en_i | input | 1 | Idle delay enable |
| cfg_hyst_long_i | input | 1 | Idle delay length: 0 = short, 1 = long |
| hw_req_i | input | 1 | Hardware clock request (1 = clock needed) |
| gate_en_o | output | 1 | Registered enable to the clock gating cell |
| status_o | output | 1 | Synchronised gate state, two cycles behind |

## Verification
Two events can fall on the same edge: the idle countdown reaching its limit and a new hardware request arriving. They compete for that edge, and the request has to win. The bench idles the request line for seven edges under the short delay, then raises it for exactly the eighth edge. It expects `gate_en_o` to stay high and then to need a full eight fresh idle edges before it drops. It then checks that a run of seven idle edges after the cancel still leaves the gate open.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
  typedef struct packed {
    logic sel;        // 1 = software control
    logic en;         // software enable
    logic hyst_en;    // idle delay on
    logic hyst_long;  // 1 = long idle delay
  } ckg_cfg_t;

  localparam ckg_cfg_t CKG_CFG_RESET = '{sel: 1'b1, en: 1'b1, hyst_en: 1'b0, hyst_long: 1'b0};
endpackage

// File: rtl/ckg_cfg_regs.sv
module ckg_cfg_regs
  import ckg_pkg::*;
#(
  parameter bit HW_ONLY = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     we,
  input  ckg_cfg_t wdata,
  output ckg_cfg_t cfg_q
);
  ckg_cfg_t cfg_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_r <= CKG_CFG_RESET;
    end else if (we) begin
      cfg_r <= wdata;
    end
  end

  generate
    if (HW_ONLY) begin : g_hw_only
      always_comb begin
        cfg_q     = cfg_r;
        cfg_q.sel = 1'b0;
        cfg_q.en  = 1'b0;
      end
    end else begin : g_sel
      assign cfg_q = cfg_r;
    end
  endgenerate
endmodule

// File: rtl/ckg_gate_fsm.sv
module ckg_gate_fsm
  import ckg_pkg::*;
#(
  parameter int LOW_DLY  = 8,
  parameter int HIGH_DLY = 64
) (
  input  logic     clk,
  input  logic     rst,
  input  ckg_cfg_t cfg,
  input  logic     hw_req,
  output logic     gate_q
);
  localparam int CW = $clog2(HIGH_DLY + 1);
  localparam logic [CW-1:0] LO_LAST = CW'(LOW_DLY - 1);
  localparam logic [CW-1:0] HI_LAST = CW'(HIGH_DLY - 1);

  logic [CW-1:0] idle_cnt;
  logic [CW-1:0] last_idx;

  always_comb begin
    if (!cfg.hyst_en)      last_idx = '0;
    else if (cfg.hyst_long) last_idx = HI_LAST;
    else                    last_idx = LO_LAST;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q   <= 1'b1;
      idle_cnt <= '0;
    end else if (cfg.sel) begin
      gate_q   <= cfg.en;
      idle_cnt <= '0;
    end else if (hw_req) begin
      gate_q   <= 1'b1;
      idle_cnt <= '0;
    end else if (gate_q) begin
      if (idle_cnt >= last_idx) begin
        gate_q   <= 1'b0;
        idle_cnt <= '0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  assert_req_opens_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg.sel && hw_req) |=> gate_q);

  assert_sw_follows_R2: assert property (@(posedge clk) disable iff (rst)
    cfg.sel |=> (gate_q == $past(cfg.en)));

  assert_close_needs_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!cfg.sel && !$past(cfg.sel) && $fell(gate_q)) |-> !$past(hw_req));

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    idle_cnt < CW'(HIGH_DLY));
endmodule

// File: rtl/ckg_sync.sv
module ckg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];

  assert_status_lag_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst, STAGES) |-> (q == $past(d, STAGES)));
endmodule

// File: rtl/ckgate_ctrl.sv
module ckgate_ctrl
  import ckg_pkg::*;
#(
  parameter bit HW_ONLY     = 1'b0,
  parameter int LOW_DLY     = 8,
  parameter int HIGH_DLY    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_we_i,
  input  logic cfg_sel_i,
  input  logic cfg_en_i,
  input  logic cfg_hyst_en_i,
  input  logic cfg_hyst_long_i,
  input  logic hw_req_i,
  output logic gate_en_o,
  output logic status_o
);
  ckg_cfg_t wdata, cfg;
  logic gate;

  assign wdata = '{sel: cfg_sel_i, en: cfg_en_i, hyst_en: cfg_hyst_en_i, hyst_long: cfg_hyst_long_i};

  ckg_cfg_regs #(.HW_ONLY(HW_ONLY)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we_i), .wdata(wdata), .cfg_q(cfg)
  );

  ckg_gate_fsm #(.LOW_DLY(LOW_DLY), .HIGH_DLY(HIGH_DLY)) u_fsm (
    .clk(clk), .rst(rst), .cfg(cfg), .hw_req(hw_req_i), .gate_q(gate)
  );

  ckg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(gate), .q(status_o)
  );

  assign gate_en_o = gate;

  generate
    if (HW_ONLY) begin : g_hw_chk
      assert_hw_only_auto_R9: assert property (@(posedge clk) disable iff (rst)
        hw_req_i |=> gate_en_o);
    end
  endgenerate
endmodule

// File: tb/ckgate_ctrl_tb.sv
module ckgate_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0, sel = 1'b1, en = 1'b1, hen = 1'b0, hlong = 1'b0;
  logic req = 1'b0, req2 = 1'b1;
  logic gate, status, gate2, status2;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ckgate_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_we_i(we), .cfg_sel_i(sel), .cfg_en_i(en),
    .cfg_hyst_en_i(hen), .cfg_hyst_long_i(hlong), .hw_req_i(req),
    .gate_en_o(gate), .status_o(status)
  );

  ckgate_ctrl #(.HW_ONLY(1'b1)) u_dut_hw (
    .clk(clk), .rst(rst), .cfg_we_i(we), .cfg_sel_i(sel), .cfg_en_i(en),
    .cfg_hyst_en_i(hen), .cfg_hyst_long_i(hlong), .hw_req_i(req2),
    .gate_en_o(gate2), .status_o(status2)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic e, input logic he, input logic hl);
    sel = s; en = e; hen = he; hlong = hl; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 gate after reset", gate, 1'b1);
    chk("R1 status after reset", status, 1'b1);
    wait_n(10);
    chk("R1 gate held in sw mode", gate, 1'b1);
  endtask

  task automatic t_sw_and_status();
    wr(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R2 gate before update", gate, 1'b1);
    wait_n(1);
    chk("R2 gate off", gate, 1'b0);
    chk("R8 status lag 1", status, 1'b1);
    wait_n(1);
    chk("R8 status lag 2", status, 1'b1);
    wait_n(1);
    chk("R8 status settled", status, 1'b0);
    chk("R9 hw-only ignores sel/en", gate2, 1'b1);
    wr(1'b1, 1'b1, 1'b0, 1'b0);
    wait_n(1);
    chk("R2 gate on", gate, 1'b1);
    wait_n(2);
    chk("R8 status on", status, 1'b1);
  endtask

  task automatic t_auto_plain();
    req = 1'b1;
    wr(1'b0, 1'b0, 1'b0, 1'b0);
    wait_n(1);
    chk("R3 auto gate with req", gate, 1'b1);
    req = 1'b0;
    wait_n(1);
    chk("R4 close on first idle", gate, 1'b0);
    req = 1'b1;
    wait_n(1);
    chk("R3 reopen on req", gate, 1'b1);
  endtask

  task automatic t_short();
    wr(1'b0, 1'b0, 1'b1, 1'b0);
    req = 1'b0;
    wait_n(7);
    chk("R5 open after 7 idle", gate, 1'b1);
    wait_n(1);
    chk("R5 closed after 8 idle", gate, 1'b0);
  endtask

  task automatic t_cancel();
    req = 1'b1;
    wait_n(1);
    req = 1'b0;
    wait_n(7);
    req = 1'b1;
    wait_n(1);
    chk("R7 req on final edge cancels", gate, 1'b1);
    req = 1'b0;
    wait_n(7);
    chk("R7 count restarted", gate, 1'b1);
    wait_n(1);
    chk("R7 closes after full delay", gate, 1'b0);
  endtask

  task automatic t_long();
    req = 1'b1;
    wait_n(1);
    wr(1'b0, 1'b0, 1'b1, 1'b1);
    req = 1'b0;
    wait_n(63);
    chk("R6 open after 63 idle", gate, 1'b1);
    wait_n(1);
    chk("R6 closed after 64 idle", gate, 1'b0);
  endtask

  task automatic t_hw_only();
    wr(1'b1, 1'b0, 1'b0, 1'b0);
    req2 = 1'b0;
    wait_n(1);
    chk("R9 hw-only closes on idle", gate2, 1'b0);
    chk("R2 main dut sw off", gate, 1'b0);
    req2 = 1'b1;
    wait_n(1);
    chk("R9 hw-only opens on req", gate2, 1'b1);
    chk("R2 main dut stays off", gate, 1'b0);
  endtask

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_sw_and_status();
    t_auto_plain();
    t_short();
    t_cancel();
    t_long();
    t_hw_only();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule